// File: doc/BRIEF.md
# Sixteen-bit capture-compare timer channel

This block is a single timer channel built around a free-running 16-bit up-counter. Two compare registers are checked against the counter on every counting cycle. Each one raises its own one-cycle interrupt pulse when it matches. Two capture inputs are passed through two-flop synchronizers, and their rising edges latch the counter into two capture registers. Each latch comes with its own interrupt pulse.

An output flip-flop drives a timer pin. It can be inverted by any of the four hardware events, and each event has its own enable bit. Software can also invert, set or clear it through a two-bit command.

Software reaches the channel through a simple register bus with a one-cycle registered read. A snapshot address returns the live counter at the moment of the read and keeps that value for later reads.

Address map (word addresses on `addr`):

| Address | Access | Content |
|---|---|---|
| 0 | read/write | toggle enables in bits [3:0] |
| 1 | write | flip-flop command in bits [1:0] |
| 1 | read | flip-flop state in bit 0 |
| 2 | read/write | compare A |
| 3 | read/write | compare B |
| 4 | read-only | capture A |
| 5 | read-only | capture B |
| 6 | read | live counter, stored as the snapshot |
| 7 | read | last stored snapshot |

Top module: `cc_timer16`

## Requirements
- R1: The counter resets to 0. It adds one at every clock edge where `cnt_en` is high, holds its value when `cnt_en` is low, and wraps from 0xFFFF to 0x0000.
- R2: At an edge where `cnt_en` is high and the counter equals compare A (address 2), `irq_cmp[0]` is high for the following cycle. Compare B (address 3) drives `irq_cmp[1]` in the same way.
- R3: A rising edge on `cap_in[i]` is synchronized by two flops. The edge is taken at the third clock edge after the input rises. At that edge the capture register (address 4 for input 0, address 5 for input 1) loads the counter value that was present just before the edge.
- R4: `irq_cap[i]` is high for exactly one cycle, starting at the edge where capture register i is loaded.
- R5: The toggle enables at address 0 each let one event invert `ff_out`: bit 0 for the compare A match, bit 1 for the compare B match, bit 2 for capture A, bit 3 for capture B. A disabled event leaves `ff_out` unchanged.
- R6: Writing bits [1:0] of address 1 sets the next `ff_out` as follows: 00 inverts it, 01 sets it to 1, 10 clears it to 0, 11 leaves it unchanged. In that cycle the command overrides all hardware events.
- R7: When several enabled events occur at the same edge, `ff_out` inverts only once.
- R8: A read of address 6 returns, one cycle later, the counter value present at the read edge, and stores it. A read of address 7 returns the stored value.
- R9: After reset, `ff_out`, all interrupts, the toggle enables, the compare registers, the capture registers and the snapshot are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| cap_in | input | 2 | Asynchronous capture trigger inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| irq_cmp | output | 2 | Compare match interrupt pulses |
| irq_cap | output | 2 | Capture interrupt pulses |
| ff_out | output | 1 | Timer flip-flop output |

## Verification
The results arrive at different delays after their stimulus:

- **Compare interrupts and flip-flop changes** are due one cycle after the edge that evaluates the match, the trigger edge or the command.
- **Captures** land three edges after the trigger input rises.
- **Read data** is due one cycle after the read strobe.

A reference model runs in the bench at each rising edge. From the bench's own inputs it pushes one expected item per cycle into a queue: the interrupt vectors and the flip-flop state. A monitor pops one item at each falling edge and compares it with the outputs, so each item is checked in the cycle in which the registered result is visible. Register reads are compared at the falling edge after the read cycle, against values the model recorded at the read edge.

// File: rtl/cc_timer16.sv
module cc_timer16 #(
  parameter int W  = 16,
  parameter int NC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic [NC-1:0] cap_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [NC-1:0] irq_cmp,
  output logic [NC-1:0] irq_cap,
  output logic          ff_out
);
  localparam int NE = 2 * NC;

  logic [W-1:0]  cnt, snap;
  logic [W-1:0]  cmp_r [NC];
  logic [W-1:0]  cap_r [NC];
  logic [NE-1:0] tog_en;
  logic [NC-1:0] s1, s2, s3;
  logic [NC-1:0] hit, edge_det;
  logic          sw_cmd, tog;
  logic [W-1:0]  rd_mux;

  assign edge_det = s2 & ~s3;
  assign sw_cmd   = wr_en && (addr == 3'd1);
  assign tog      = |({edge_det, hit} & tog_en);

  for (genvar i = 0; i < NC; i++) begin : g_ch
    assign hit[i] = cnt_en && (cnt == cmp_r[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_r[i]   <= '0;
        cap_r[i]   <= '0;
        irq_cmp[i] <= 1'b0;
        irq_cap[i] <= 1'b0;
      end else begin
        if (wr_en && addr == 3'(2 + i)) cmp_r[i] <= wdata;
        if (edge_det[i]) cap_r[i] <= cnt;
        irq_cmp[i] <= hit[i];
        irq_cap[i] <= edge_det[i];
      end
    end

    a_r4_cap_irq: assert property (@(posedge clk) disable iff (rst)
      irq_cap[i] |-> cap_r[i] == $past(cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      tog_en <= '0;
      ff_out <= 1'b0;
    end else begin
      if (cnt_en) cnt <= cnt + 1'b1;
      s1 <= cap_in;
      s2 <= s1;
      s3 <= s2;
      if (wr_en && addr == 3'd0) tog_en <= wdata[NE-1:0];
      if (sw_cmd) begin
        case (wdata[1:0])
          2'b00:   ff_out <= ~ff_out;
          2'b01:   ff_out <= 1'b1;
          2'b10:   ff_out <= 1'b0;
          default: ff_out <= ff_out;
        endcase
      end else if (tog) begin
        ff_out <= ~ff_out;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_mux = W'(tog_en);
      3'd1:    rd_mux = W'(ff_out);
      3'd2:    rd_mux = cmp_r[0];
      3'd3:    rd_mux = cmp_r[1];
      3'd4:    rd_mux = cap_r[0];
      3'd5:    rd_mux = cap_r[1];
      3'd6:    rd_mux = cnt;
      default: rd_mux = snap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      snap  <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
      if (addr == 3'd6) snap <= cnt;
    end
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> cnt == W'($past(cnt) + 1'b1));
  a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt));
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (sw_cmd && wdata[1:0] == 2'b01) |=> ff_out);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_cmd && wdata[1:0] == 2'b10) |=> !ff_out);
  a_r7_single_flip: assert property (@(posedge clk) disable iff (rst)
    (!sw_cmd && tog) |=> ff_out != $past(ff_out));
  a_r8_snapshot: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd6) |=> rdata == $past(cnt));
endmodule

// File: tb/test_cc_timer16.sv
module test_cc_timer16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic [1:0]  cap_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq_cmp, irq_cap;
  logic        ff_out;

  int tests = 0, fails = 0;

  cc_timer16 i_cc_timer16 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cap_in(cap_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_cmp(irq_cmp), .irq_cap(irq_cap), .ff_out(ff_out)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0] icmp;
    logic [1:0] icap;
    logic       ff;
  } exp_t;
  exp_t q[$];

  logic [15:0] mcnt = '0, mcmp0 = '0, mcmp1 = '0, mcap0 = '0, mcap1 = '0, msnap = '0;
  logic [3:0]  men = '0;
  logic [1:0]  m1 = '0, m2 = '0, m3 = '0;
  logic        mff = 1'b0;

  // reference model of the requirements, driven from bench inputs only
  always @(posedge clk) begin
    if (rst) begin
      mcnt = '0; mcmp0 = '0; mcmp1 = '0; mcap0 = '0; mcap1 = '0; msnap = '0;
      men = '0; m1 = '0; m2 = '0; m3 = '0; mff = 1'b0;
      q.delete();
    end else begin
      logic [1:0] h, e;
      exp_t it;
      h = {cnt_en && mcnt == mcmp1, cnt_en && mcnt == mcmp0};
      e = m2 & ~m3;
      if (e[0]) mcap0 = mcnt;
      if (e[1]) mcap1 = mcnt;
      if (rd_en && addr == 3'd6) msnap = mcnt;
      if (wr_en && addr == 3'd1) begin
        if (wdata[1:0] == 2'b00) mff = ~mff;
        else if (wdata[1:0] == 2'b01) mff = 1'b1;
        else if (wdata[1:0] == 2'b10) mff = 1'b0;
      end else if (|({e, h} & men)) mff = ~mff;
      if (wr_en && addr == 3'd0) men = wdata[3:0];
      if (wr_en && addr == 3'd2) mcmp0 = wdata;
      if (wr_en && addr == 3'd3) mcmp1 = wdata;
      m3 = m2; m2 = m1; m1 = cap_in;
      if (cnt_en) mcnt = mcnt + 16'd1;
      it.icmp = h; it.icap = e; it.ff = mff;
      q.push_back(it);
    end
  end

  // monitor: one expected item per cycle
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      tests++;
      if (irq_cmp !== x.icmp) begin
        fails++;
        $display("FAIL R2 irq_cmp actual %b expected %b", irq_cmp, x.icmp);
      end
      if (irq_cap !== x.icap) begin
        fails++;
        $display("FAIL R4 irq_cap actual %b expected %b", irq_cap, x.icap);
      end
      if (ff_out !== x.ff) begin
        fails++;
        $display("FAIL R5/R6/R7 ff_out actual %b expected %b", ff_out, x.ff);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input string req, input bit use_snap,
                          input logic [15:0] exp_fixed);
    logic [15:0] e;
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    case (a)
      3'd4:    e = mcap0;
      3'd5:    e = mcap1;
      3'd6,
      3'd7:    e = msnap;
      default: e = exp_fixed;
    endcase
    if (!use_snap) e = exp_fixed;
    tests++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s read addr %0d actual %h expected %h", req, a, rdata, e);
    end
  endtask

  task automatic run(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    tests++;
    if (ff_out !== 1'b0 || irq_cmp !== 2'b00 || irq_cap !== 2'b00) begin
      fails++;
      $display("FAIL R9 outputs actual %b%b%b expected 00000", ff_out, irq_cmp, irq_cap);
    end
    rd_check(3'd0, "R9", 0, 16'h0000);
    rd_check(3'd2, "R9", 0, 16'h0000);
    rd_check(3'd4, "R9", 0, 16'h0000);
    rd_check(3'd7, "R9", 0, 16'h0000);
    // R1 counting, R2 matches with toggles disabled (R5)
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd9);
    rd_check(3'd2, "R2", 0, 16'd5);
    run(12);
    rd_check(3'd6, "R1", 0, 16'd12);
    repeat (5) @(negedge clk);
    rd_check(3'd6, "R1", 0, 16'd12);
    rd_check(3'd7, "R8", 0, 16'd12);
    // R6 software commands
    wr(3'd1, 16'h0001);
    rd_check(3'd1, "R6", 0, 16'h0001);
    wr(3'd1, 16'h0003);
    wr(3'd1, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd1, 16'h0002);
    rd_check(3'd1, "R6", 0, 16'h0000);
    // R3/R4/R5 captures with toggles for capture A only
    wr(3'd0, 16'h0004);
    rd_check(3'd0, "R5", 0, 16'h0004);
    @(negedge clk); cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    cap_in = 2'b01;
    repeat (6) @(negedge clk);
    cap_in = 2'b11;
    repeat (6) @(negedge clk);
    cap_in = 2'b00;
    repeat (6) @(negedge clk);
    cnt_en = 1'b0;
    rd_check(3'd4, "R3", 1, 16'h0);
    rd_check(3'd5, "R3", 1, 16'h0);
    // R7 simultaneous events, R6 priority while counting
    wr(3'd0, 16'h000F);
    wr(3'd2, 16'd60);
    wr(3'd3, 16'd60);
    @(negedge clk); cnt_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (k == 10) begin wr_en = 1'b1; addr = 3'd1; wdata = 16'h0001; end
      else wr_en = 1'b0;
      cap_in = (k % 7 < 3) ? 2'b11 : 2'b00;
      @(negedge clk);
    end
    wr_en = 1'b0; cap_in = 2'b00; cnt_en = 1'b0;
    rd_check(3'd6, "R8", 1, 16'h0);
    rd_check(3'd4, "R3", 1, 16'h0);
    // R1 wrap, R2 at 0xFFFF and 0x0000
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h0000);
    run(65540);
    rd_check(3'd6, "R1", 1, 16'h0);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule